// File: doc/BRIEF.md
# UART Channel Register and Command Controller

This block is the register front end of one UART channel. A byte-wide register bus reaches it through a 64-byte window. It holds two mode registers that share one offset through a pointer, status and interrupt registers, and two read-only divisor bytes. It decodes one packed command byte into a miscellaneous action, a transmitter action and a receiver action. A holding register passes transmit bytes to a valid/ready byte stream. A shift-register FIFO holds received bytes, which can arrive from a byte stream or from a line-break event. One level interrupt is driven from the masked interrupt status.

A bus access is a single-cycle strobe. Read data is combinational in the strobe cycle. State changes, including the FIFO pop on a data read, take effect at the clock edge that ends the strobe. The interrupt status is derived from registered flags, so it follows a register write one cycle later.

Top module: `uart_regctl`

## Requirements
- R1: Only address bits [5:0] are decoded. Reads: 0x00 mode, 0x04 status, 0x0C receive data, 0x14 interrupt status, 0x18 divisor high, 0x1C divisor low. Every other offset, including 0x10, reads 0. Writes to 0x04, 0x10, 0x18 and 0x1C change nothing.
- R2: A write to 0x00 stores into the mode register picked by the pointer and then sets the pointer to 1. A read of 0x00 returns the picked register and leaves the pointer where it is.
- R3: Status bit0 is set when the FIFO is not empty and bit1 when it is full. Bit2 equals the transmitter enable. Bit3 is set while no transmit byte is pending. Bits 7:4 read 0.
- R4: Interrupt status bit0 equals transmit ready, and bit2 is the delta-break flag. Bits 6:3 and bit7 read 0. A write to 0x14 sets the mask. `irq_o` is high exactly when (interrupt status AND mask) is non-zero.
- R5: Interrupt status bit1 follows status bit1 (full) when mode register 0 bit6 is set, and status bit0 (ready) when that bit is clear.
- R6: Command bits [6:4] select the miscellaneous action. 1 clears the mode pointer. 2 disables the receiver and empties the FIFO. 3 disables the transmitter and drops any pending byte. 5 clears the delta-break flag. Values 0, 4, 6 and 7 have no effect.
- R7: Command bits [3:2] act on the transmitter and bits [1:0] on the receiver: 1 enables, 2 disables, and 3 changes nothing. The miscellaneous action applies first, then the transmitter action, then the receiver action.
- R8: A write to 0x0C latches the byte and clears transmit empty. While the transmitter is enabled and a byte is pending, `tx_valid_o` is high and `tx_data_o` holds steady. Transmit empty is set again after the cycle in which `tx_ready_i` accepts the byte.
- R9: `rx_ready_o` is high when the receiver is enabled, the FIFO is not full and no break is being signalled. Reads of 0x0C return bytes in arrival order, and a read with the FIFO empty returns 0x00. The FIFO holds 4 bytes.
- R10: A `brk_i` pulse sets the delta-break flag and pushes a 0x00 byte. When the FIFO is full, the 0x00 byte replaces the newest entry.
- R11: After reset, both mode registers, the mask and the interrupt status are 0, both directions are disabled, the FIFO is empty and status reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address; only [5:0] decoded |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive byte accepted |
| brk_i | input | 1 | Line break detected (pulse) |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Sink accepts transmit byte |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong pointer or enable flag shows up at the ports at the next bus read or on the stream handshakes in the cycle after the command write. A bad FIFO count appears as lost, repeated or reordered bytes on the following data reads, or as `rx_ready_o` asserted while full. Flag errors reach `irq_o` one cycle after the write that caused them, so the bench checks status, interrupt status and the interrupt pin right after each command, and checks byte order by draining the FIFO.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;
  localparam int unsigned OFS_W = 6;

  localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CMD  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_DATA = 6'h0C;
  localparam logic [OFS_W-1:0] OFS_AUX  = 6'h10;
  localparam logic [OFS_W-1:0] OFS_INT  = 6'h14;
  localparam logic [OFS_W-1:0] OFS_DIVH = 6'h18;
  localparam logic [OFS_W-1:0] OFS_DIVL = 6'h1C;

  localparam int unsigned ST_RXRDY = 0;
  localparam int unsigned ST_FULL  = 1;
  localparam int unsigned ST_TXRDY = 2;
  localparam int unsigned ST_TXEMP = 3;

  localparam int unsigned IS_TX  = 0;
  localparam int unsigned IS_RX  = 1;
  localparam int unsigned IS_BRK = 2;

  localparam int unsigned MODE_RXSRC = 6;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_CLR = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_CLR = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    DIR_NOP  = 2'd0,
    DIR_ON   = 2'd1,
    DIR_OFF  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_e;

  typedef struct packed {
    logic ptr_clr;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    dir_e tx_act;
    dir_e rx_act;
  } cmd_t;
endpackage

// File: rtl/uart_cmd_dec.sv
module uart_cmd_dec
  import uart_regctl_pkg::*;
(
  input  logic [7:0] cmd_i,
  output cmd_t       dec_o
);
  misc_e misc;

  always_comb begin
    misc          = misc_e'(cmd_i[6:4]);
    dec_o         = '0;
    dec_o.tx_act  = dir_e'(cmd_i[3:2]);
    dec_o.rx_act  = dir_e'(cmd_i[1:0]);
    unique case (misc)
      MISC_PTR_CLR: dec_o.ptr_clr = 1'b1;
      MISC_RX_RST:  dec_o.rx_rst  = 1'b1;
      MISC_TX_RST:  dec_o.tx_rst  = 1'b1;
      MISC_BRK_CLR: dec_o.brk_clr = 1'b1;
      default:      ;
    endcase
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              force_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_pop, cnt_n;
  logic              pop_eff, do_push, at_full;
  logic [IDX_W-1:0]  wr_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == DEPTH_C);
  assign count_o = cnt_q;
  assign head_o  = empty_o ? '0 : mem_q[0];

  always_comb begin
    pop_eff = pop_i && !empty_o;
    cnt_pop = cnt_q - CNT_W'(pop_eff);
    at_full = (cnt_pop == DEPTH_C);
    // overwrite of newest entry only on forced push into a full buffer
    do_push = push_i && (!at_full || force_i);
    wr_idx  = at_full ? IDX_W'(DEPTH - 1) : IDX_W'(cnt_pop);
    cnt_n   = cnt_pop + CNT_W'(do_push && !at_full);
    if (flush_i) cnt_n = '0;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DATA_W-1:0] shift_in;
    if (g == DEPTH - 1) begin : g_last
      assign shift_in = '0;
    end else begin : g_mid
      assign shift_in = mem_q[g+1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (do_push && wr_idx == IDX_W'(g)) begin
        mem_q[g] <= push_data_i;
      end else if (pop_eff) begin
        mem_q[g] <= shift_in;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C); // R9
  AST_FIFO_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R6
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              drop_i,
  input  logic              en_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  output logic              empty_o
);
  logic              pend_q;
  logic [DATA_W-1:0] data_q;

  assign tx_valid_o = pend_q && en_i;
  assign tx_data_o  = data_q;
  assign empty_o    = !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (load_i) data_q <= load_data_i;
      if (drop_i)                       pend_q <= 1'b0;
      else if (load_i)                  pend_q <= 1'b1;
      else if (tx_valid_o && tx_ready_i) pend_q <= 1'b0;
    end
  end

  AST_TX_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !load_i && !drop_i) |=> $stable(tx_data_o)); // R8
  AST_TX_EMPTY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_ready_i && !load_i) |=> empty_o); // R8
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
  import uart_regctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter logic [7:0]  DIV_HI_INIT = 8'h00,
  parameter logic [7:0]  DIV_LO_INIT = 8'h1A,
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  input  logic              brk_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  logic [OFS_W-1:0] ofs;
  logic             wr, rd, cmd_wr, mode_wr, data_wr, mask_wr, data_rd;
  cmd_t             dec;

  logic [7:0] mode_q [2];
  logic       ptr_q;
  logic [7:0] imr_q;
  logic       tx_en_q, rx_en_q, dbrk_q;
  logic       tx_en_n, rx_en_n;

  logic [7:0]       fifo_head;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_empty, fifo_full;
  logic             tx_empty;
  logic             rx_push;
  logic [7:0]       status, isr;

  assign ofs     = addr_i[OFS_W-1:0];
  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign cmd_wr  = wr && (ofs == OFS_CMD);
  assign mode_wr = wr && (ofs == OFS_MODE);
  assign data_wr = wr && (ofs == OFS_DATA);
  assign mask_wr = wr && (ofs == OFS_INT);
  assign data_rd = rd && (ofs == OFS_DATA);

  uart_cmd_dec u_dec (
    .cmd_i (wdata_i),
    .dec_o (dec)
  );

  // misc first, then transmitter field, then receiver field
  always_comb begin
    tx_en_n = tx_en_q;
    rx_en_n = rx_en_q;
    if (cmd_wr) begin
      if (dec.tx_rst) tx_en_n = 1'b0;
      if (dec.rx_rst) rx_en_n = 1'b0;
      if (dec.tx_act == DIR_ON)  tx_en_n = 1'b1;
      if (dec.tx_act == DIR_OFF) tx_en_n = 1'b0;
      if (dec.rx_act == DIR_ON)  rx_en_n = 1'b1;
      if (dec.rx_act == DIR_OFF) rx_en_n = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      ptr_q     <= 1'b0;
      imr_q     <= '0;
      tx_en_q   <= 1'b0;
      rx_en_q   <= 1'b0;
      dbrk_q    <= 1'b0;
    end else begin
      tx_en_q <= tx_en_n;
      rx_en_q <= rx_en_n;
      if (mode_wr) begin
        mode_q[ptr_q] <= wdata_i;
        ptr_q         <= 1'b1;
      end else if (cmd_wr && dec.ptr_clr) begin
        ptr_q <= 1'b0;
      end
      if (mask_wr) imr_q <= wdata_i;
      dbrk_q <= (dbrk_q && !(cmd_wr && dec.brk_clr)) || brk_i;
    end
  end

  assign rx_ready_o = rx_en_q && !fifo_full && !brk_i;
  assign rx_push    = brk_i || (rx_valid_i && rx_ready_o);

  uart_rx_fifo #(
    .DEPTH  (FIFO_DEPTH),
    .DATA_W (8)
  ) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (cmd_wr && dec.rx_rst),
    .push_i      (rx_push),
    .force_i     (brk_i),
    .push_data_i (brk_i ? 8'h00 : rx_data_i),
    .pop_i       (data_rd),
    .head_o      (fifo_head),
    .count_o     (fifo_cnt),
    .empty_o     (fifo_empty),
    .full_o      (fifo_full)
  );

  uart_tx_hold #(
    .DATA_W (8)
  ) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (data_wr),
    .load_data_i (wdata_i),
    .drop_i      (cmd_wr && dec.tx_rst),
    .en_i        (tx_en_q),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_ready_i  (tx_ready_i),
    .empty_o     (tx_empty)
  );

  always_comb begin
    status           = '0;
    status[ST_RXRDY] = !fifo_empty;
    status[ST_FULL]  = fifo_full;
    status[ST_TXRDY] = tx_en_q;
    status[ST_TXEMP] = tx_empty;
    isr              = '0;
    isr[IS_TX]       = status[ST_TXRDY];
    isr[IS_RX]       = mode_q[0][MODE_RXSRC] ? status[ST_FULL] : status[ST_RXRDY];
    isr[IS_BRK]      = dbrk_q;
  end

  assign irq_o = |(isr & imr_q);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (ofs)
        OFS_MODE: rdata_o = mode_q[ptr_q];
        OFS_STAT: rdata_o = status;
        OFS_DATA: rdata_o = fifo_head;
        OFS_INT:  rdata_o = isr;
        OFS_DIVH: rdata_o = DIV_HI_INIT;
        OFS_DIVL: rdata_o = DIV_LO_INIT;
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_MODE_PTR_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> ptr_q); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_q == '0) |-> !irq_o); // R4
  AST_RX_OFF_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_q && !brk_i) |=> (fifo_cnt <= $past(fifo_cnt))); // R9
  AST_BRK_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |=> isr[IS_BRK]); // R10
  AST_RX_READY_NOT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o |-> (fifo_cnt < CNT_W'(FIFO_DEPTH))); // R9
endmodule

// File: tb/sim_uart_regctl.sv
module sim_uart_regctl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       rx_ready_o;
  logic       brk_i = 1'b0;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;
  logic       tx_ready_i = 1'b0;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  uart_regctl u0 (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .rx_valid_i, .rx_data_i, .rx_ready_o, .brk_i,
    .tx_valid_o, .tx_data_o, .tx_ready_i, .irq_o
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i); #1;
    req_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic exp_rdy, input string tag);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = d;
    #1 chk(8'(rx_ready_o), 8'(exp_rdy), tag);
    @(posedge clk_i); #1;
    rx_valid_i = 1'b0;
  endtask

  task automatic brk_pulse();
    @(negedge clk_i);
    brk_i = 1'b1;
    @(posedge clk_i); #1;
    brk_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] mask,
                        input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(d & mask, exp, tag);
  endtask

  task automatic t_reset();
    rd_chk(8'h04, 8'hFF, 8'h08, "R11 status");
    rd_chk(8'h14, 8'hFF, 8'h00, "R11 isr");
    rd_chk(8'h00, 8'hFF, 8'h00, "R11 mode0");
    chk(8'(irq_o), 8'h0, "R11 irq");
    chk(8'(tx_valid_o), 8'h0, "R11 tx_valid");
    chk(8'(rx_ready_o), 8'h0, "R11 rx_ready");
  endtask

  task automatic t_decode();
    wr(8'h04, 8'hFF);
    wr(8'h10, 8'hFF);
    wr(8'h18, 8'h55);
    wr(8'h1C, 8'h66);
    rd_chk(8'h04, 8'hFF, 8'h08, "R1 status after ignored writes");
    rd_chk(8'h10, 8'hFF, 8'h00, "R1 aux reads 0");
    rd_chk(8'h18, 8'hFF, 8'h00, "R1 divisor high");
    rd_chk(8'h1C, 8'hFF, 8'h1A, "R1 divisor low");
    rd_chk(8'h24, 8'hFF, 8'h00, "R1 unmapped");
    rd_chk(8'h14, 8'hFF, 8'h00, "R1 isr unchanged");
  endtask

  task automatic t_mode();
    wr(8'h00, 8'hA1);
    rd_chk(8'h00, 8'hFF, 8'h00, "R2 pointer advanced to mode1");
    wr(8'h00, 8'hB2);
    rd_chk(8'h00, 8'hFF, 8'hB2, "R2 mode1 stored");
    rd_chk(8'h40, 8'hFF, 8'hB2, "R1 alias above bit5, R2 read keeps pointer");
    wr(8'h08, 8'h10);
    rd_chk(8'h00, 8'hFF, 8'hA1, "R6 pointer cleared");
    wr(8'h00, 8'h00);
    wr(8'h08, 8'h40);
    wr(8'h08, 8'h60);
    rd_chk(8'h00, 8'hFF, 8'hB2, "R6 misc 4/6 no pointer change");
    wr(8'h08, 8'h10);
    rd_chk(8'h00, 8'hFF, 8'h00, "R2 mode0 rewritten");
    wr(8'h08, 8'h10);
  endtask

  task automatic t_tx();
    wr(8'h08, 8'h04);
    rd_chk(8'h04, 8'hFF, 8'h0C, "R3 tx enabled status");
    wr(8'h0C, 8'h5A);
    rd_chk(8'h04, 8'hFF, 8'h04, "R8 empty cleared");
    chk(8'(tx_valid_o), 8'h1, "R8 valid");
    repeat (3) @(posedge clk_i);
    #1 chk(tx_data_o, 8'h5A, "R8 data held");
    chk(8'(tx_valid_o), 8'h1, "R8 valid held");
    @(negedge clk_i); tx_ready_i = 1'b1;
    @(posedge clk_i); #1 tx_ready_i = 1'b0;
    chk(8'(tx_valid_o), 8'h0, "R8 accepted");
    rd_chk(8'h04, 8'hFF, 8'h0C, "R8 empty set after accept");
    wr(8'h08, 8'h08);
    rd_chk(8'h04, 8'hFF, 8'h08, "R7 tx disabled");
    wr(8'h0C, 8'h33);
    chk(8'(tx_valid_o), 8'h0, "R8 no offer while disabled");
    wr(8'h08, 8'h0C);
    rd_chk(8'h04, 8'hFF, 8'h00, "R7 reserved tx ignored");
    wr(8'h08, 8'h04);
    chk(8'(tx_valid_o), 8'h1, "R7 re-enable offers pending");
    chk(tx_data_o, 8'h33, "R8 pending data");
    wr(8'h08, 8'h30);
    rd_chk(8'h04, 8'hFF, 8'h08, "R6 tx reset");
    chk(8'(tx_valid_o), 8'h0, "R6 tx reset drops byte");
    wr(8'h0C, 8'h77);
    wr(8'h08, 8'h34);
    rd_chk(8'h04, 8'hFF, 8'h0C, "R7 misc before tx field");
    chk(8'(tx_valid_o), 8'h0, "R7 dropped then enabled");
  endtask

  task automatic t_rx();
    logic [7:0] d;
    push(8'h99, 1'b0, "R9 not ready when disabled");
    wr(8'h08, 8'h01);
    push(8'h11, 1'b1, "R9 ready");
    push(8'h22, 1'b1, "R9 ready");
    rd_chk(8'h04, 8'h03, 8'h01, "R3 rx ready");
    push(8'h33, 1'b1, "R9 ready");
    push(8'h44, 1'b1, "R9 ready");
    rd_chk(8'h04, 8'h03, 8'h03, "R3 full");
    push(8'h99, 1'b0, "R9 not ready when full");
    wr(8'h08, 8'h03);
    rd_chk(8'h0C, 8'hFF, 8'h11, "R9 order 1");
    rd_chk(8'h04, 8'h03, 8'h01, "R3 full cleared by pop");
    rd_chk(8'h0C, 8'hFF, 8'h22, "R9 order 2");
    rd_chk(8'h0C, 8'hFF, 8'h33, "R9 order 3");
    rd_chk(8'h0C, 8'hFF, 8'h44, "R9 order 4");
    rd_chk(8'h0C, 8'hFF, 8'h00, "R9 empty read");
    rd_chk(8'h04, 8'h03, 8'h00, "R3 empty");
    push(8'h55, 1'b1, "R7 reserved rx kept enable");
    wr(8'h08, 8'h02);
    chk(8'(rx_ready_o), 8'h0, "R7 rx disabled");
    wr(8'h08, 8'h20);
    rd_chk(8'h04, 8'h03, 8'h00, "R6 rx reset flushes");
    rd_chk(8'h0C, 8'hFF, 8'h00, "R6 flushed data");
    wr(8'h08, 8'h21);
    chk(8'(rx_ready_o), 8'h1, "R7 flush then enable");
    d = 0;
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(8'h14, 8'h01);
    chk(8'(irq_o), 8'h1, "R4 tx interrupt");
    rd_chk(8'h14, 8'hFF, 8'h01, "R4 isr tx bit");
    wr(8'h14, 8'h02);
    chk(8'(irq_o), 8'h0, "R4 masked tx");
    push(8'hC1, 1'b1, "R5 push");
    chk(8'(irq_o), 8'h1, "R5 ready source");
    wr(8'h00, 8'h40);
    rd_chk(8'h14, 8'h02, 8'h00, "R5 full source, not full");
    chk(8'(irq_o), 8'h0, "R5 irq low");
    push(8'hC2, 1'b1, "R5 push");
    push(8'hC3, 1'b1, "R5 push");
    push(8'hC4, 1'b1, "R5 push");
    rd_chk(8'h14, 8'h02, 8'h02, "R5 full source, full");
    chk(8'(irq_o), 8'h1, "R5 irq high");
    for (int i = 0; i < 4; i++) rd(8'h0C, d);
    wr(8'h08, 8'h10);
    wr(8'h00, 8'h00);
    wr(8'h08, 8'h10);
  endtask

  task automatic t_break();
    wr(8'h14, 8'h04);
    chk(8'(irq_o), 8'h0, "R10 idle");
    brk_pulse();
    chk(8'(irq_o), 8'h1, "R10 break irq");
    rd_chk(8'h14, 8'h04, 8'h04, "R10 delta bit");
    rd_chk(8'h04, 8'h01, 8'h01, "R10 byte pushed");
    rd_chk(8'h0C, 8'hFF, 8'h00, "R10 zero byte");
    push(8'hA0, 1'b1, "R10 fill");
    push(8'hB0, 1'b1, "R10 fill");
    push(8'hC0, 1'b1, "R10 fill");
    push(8'hD0, 1'b1, "R10 fill");
    brk_pulse();
    rd_chk(8'h04, 8'h03, 8'h03, "R10 still full");
    rd_chk(8'h0C, 8'hFF, 8'hA0, "R10 keep 1");
    rd_chk(8'h0C, 8'hFF, 8'hB0, "R10 keep 2");
    rd_chk(8'h0C, 8'hFF, 8'hC0, "R10 keep 3");
    rd_chk(8'h0C, 8'hFF, 8'h00, "R10 newest replaced");
    rd_chk(8'h04, 8'h01, 8'h00, "R10 drained");
    wr(8'h08, 8'h50);
    rd_chk(8'h14, 8'h04, 8'h00, "R6 break flag cleared");
    chk(8'(irq_o), 8'h0, "R6 irq cleared");
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_decode();
    t_mode();
    t_tx();
    t_rx();
    t_irq();
    t_break();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule